// File: doc/BRIEF.md
# RTC Periodic Interrupt Generator

This block produces the periodic interrupt of a real-time clock. A free-running prescaler counts cycles of the 32.768 kHz clock and emits the one-cycle second-increment strobe `sec_inc`. The strobe comes a fixed number of cycles after the prescaler wraps, so in the square-wave modes the seconds advance shortly after the falling edge of the output pulse. Minute, hour and month rollover strobes come from the external time counters and are honoured only when they coincide with `sec_inc`.

A 3-bit cycle-select register picks what the active-low pin `int_n` does. The pin can be released high or forced low. It can carry a 2 Hz or 1 Hz square wave. It can also present a held interrupt that follows a flag: the selected periodic event sets the flag, and software clears it by writing 0. A write to the seconds counter (`sec_wr`) restarts the prescaler from zero. The next second then starts from the moment of that write.

The prescaler has two states. PH_RUN moves to PH_RESYNC on `sec_wr`. PH_RESYNC returns to PH_RUN when the counter wraps, and it suppresses the increment strobe until then. The flag has two states. FL_CLEAR moves to FL_SET on an event. FL_SET moves to FL_CLEAR on a write of 0 with no event in the same cycle.

Top module: `rtc_periodic_irq`

## Requirements
- R1: After reset the cycle select is 000, the flag reads 0, `int_n` is 1, and the prescaler starts at phase 0 in PH_RUN.
- R2: `sec_inc` is a one-cycle pulse in the cycle where the prescaler phase equals INC_DLY, giving one pulse every 2^CNT_W cycles while nothing writes the seconds counter.
- R3: In select codes 010 and 011, `sec_inc` is seen exactly INC_DLY cycles after a falling edge of `int_n`.
- R4: With select code 000, `int_n` is 1 whatever the flag holds, and no event sets the flag.
- R5: With select code 001, `int_n` is 0 whatever the flag holds, and no event sets the flag.
- R6: Code 011 drives `int_n` as prescaler bit CNT_W-1, a 1 Hz 50% wave that falls as the phase wraps to 0. Code 010 drives `int_n` as bit CNT_W-2, a 2 Hz 50% wave. Each falling edge that is not caused by a seconds write sets the flag.
- R7: Code 100 sets the flag on every `sec_inc`. In codes 100 to 111, `int_n` equals the inverse of the flag, so the pin falls together with the selected increment.
- R8: A flag write with data 0 clears the flag in the next cycle. A flag write with data 1 has no effect. An event in the same cycle as a clear leaves the flag set.
- R9: When `sec_wr` is sampled, the prescaler phase becomes 0, so `int_n` is low in the next cycle in codes 010 and 011. No `sec_inc` occurs until 2^CNT_W+INC_DLY cycles after the write edge.
- R10: Codes 101, 110 and 111 set the flag only when `min_roll`, `hour_roll` or `month_roll` respectively is high in a cycle with `sec_inc`. A rollover strobe in any other cycle is ignored.
- R11: A select write takes effect in the next cycle and does not change the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz timebase clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_wr | input | 1 | Write strobe for the cycle-select register |
| sel_wdata | input | 3 | New cycle-select code |
| flag_wr | input | 1 | Write strobe for the interrupt flag |
| flag_wdata | input | 1 | Flag write data; only 0 acts |
| sec_wr | input | 1 | Seconds counter is being rewritten |
| min_roll | input | 1 | Seconds wrapped to 00 |
| hour_roll | input | 1 | Minutes and seconds wrapped to 00 |
| month_roll | input | 1 | Day-of-month wrapped to the first at 00:00:00 |
| sec_inc | output | 1 | Second-counter increment strobe |
| flag | output | 1 | Interrupt flag |
| int_n | output | 1 | Active-low periodic interrupt pin |

## Verification
The embedded properties check on every cycle the properties that hold locally in time:
- The increment strobe never lasts two cycles.
- No increment follows a seconds write in the next cycle, and the square waves restart low.
- A set flag persists unless a clear is written.
- A level-mode pin only falls right after an increment, and an event is only accepted together with the strobe.
- The off mode never sets the flag.

Only the bench's scenarios can show the long-range timing: the exact INC_DLY lag after each pulse fall, and the full second plus delay from a seconds write to the next strobe. The same holds for the masking of stray rollover strobes across many seconds, and for a clear losing to a coincident event.

// File: rtl/rtc_pi_pkg.sv
package rtc_pi_pkg;

    typedef enum logic [2:0] {
        CS_OFF  = 3'b000,
        CS_LOW  = 3'b001,
        CS_P2HZ = 3'b010,
        CS_P1HZ = 3'b011,
        CS_LSEC = 3'b100,
        CS_LMIN = 3'b101,
        CS_LHR  = 3'b110,
        CS_LMON = 3'b111
    } cyc_sel_e;

    typedef enum logic {
        PH_RUN,
        PH_RESYNC
    } phase_e;

    typedef enum logic {
        FL_CLEAR,
        FL_SET
    } flag_e;

endpackage

// File: rtl/rtc_pi_prescaler.sv
module rtc_pi_prescaler
    import rtc_pi_pkg::*;
#(
    parameter int CNT_W   = 15,
    parameter int INC_DLY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_wr,
    output logic sec_inc,
    output logic wave_1hz,
    output logic wave_2hz,
    output logic fall_1hz,
    output logic fall_2hz
);

    localparam logic [CNT_W-1:0] DLY_V = CNT_W'(INC_DLY);

    phase_e            ph_q, ph_d;
    logic [CNT_W-1:0]  cnt_q;
    logic              wrap, half_wrap;

    assign wrap      = &cnt_q;
    assign half_wrap = &cnt_q[CNT_W-2:0];

    // next-phase logic
    always_comb begin
        unique case (ph_q)
            PH_RUN:    ph_d = sec_wr ? PH_RESYNC : PH_RUN;
            PH_RESYNC: ph_d = sec_wr ? PH_RESYNC : (wrap ? PH_RUN : PH_RESYNC);
            default:   ph_d = PH_RUN;
        endcase
    end

    // state register and sub-second counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_RUN;
            cnt_q <= '0;
        end else begin
            ph_q  <= ph_d;
            cnt_q <= sec_wr ? '0 : cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        sec_inc  = (ph_q == PH_RUN) && (cnt_q == DLY_V);
        wave_1hz = cnt_q[CNT_W-1];
        wave_2hz = cnt_q[CNT_W-2];
        fall_1hz = wrap && !sec_wr;
        fall_2hz = half_wrap && !sec_wr;
    end

    AST_INC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sec_inc |=> !sec_inc); // R2
    AST_WR_NO_INC: assert property (@(posedge clk) disable iff (!rst_n)
        sec_wr |=> !sec_inc); // R9
    AST_WR_WAVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sec_wr |=> (!wave_1hz && !wave_2hz)); // R9

endmodule

// File: rtl/rtc_pi_evsel.sv
module rtc_pi_evsel
    import rtc_pi_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  cyc_sel_e sel,
    input  logic     sec_inc,
    input  logic     fall_1hz,
    input  logic     fall_2hz,
    input  logic     min_roll,
    input  logic     hour_roll,
    input  logic     month_roll,
    output logic     ev
);

    always_comb begin
        unique case (sel)
            CS_OFF:  ev = 1'b0;
            CS_LOW:  ev = 1'b0;
            CS_P2HZ: ev = fall_2hz;
            CS_P1HZ: ev = fall_1hz;
            CS_LSEC: ev = sec_inc;
            CS_LMIN: ev = sec_inc && min_roll;
            CS_LHR:  ev = sec_inc && hour_roll;
            CS_LMON: ev = sec_inc && month_roll;
            default: ev = 1'b0;
        endcase
    end

    AST_EV_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && sel[2]) |-> sec_inc); // R10

endmodule

// File: rtl/rtc_periodic_irq.sv
module rtc_periodic_irq
    import rtc_pi_pkg::*;
#(
    parameter int CNT_W   = 15,
    parameter int INC_DLY = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_wr,
    input  logic [2:0] sel_wdata,
    input  logic       flag_wr,
    input  logic       flag_wdata,
    input  logic       sec_wr,
    input  logic       min_roll,
    input  logic       hour_roll,
    input  logic       month_roll,
    output logic       sec_inc,
    output logic       flag,
    output logic       int_n
);

    cyc_sel_e sel_q;
    flag_e    fl_q, fl_d;
    logic     ev, clr_req;
    logic     wave_1hz, wave_2hz, fall_1hz, fall_2hz;

    rtc_pi_prescaler #(
        .CNT_W   (CNT_W),
        .INC_DLY (INC_DLY)
    ) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_wr   (sec_wr),
        .sec_inc  (sec_inc),
        .wave_1hz (wave_1hz),
        .wave_2hz (wave_2hz),
        .fall_1hz (fall_1hz),
        .fall_2hz (fall_2hz)
    );

    rtc_pi_evsel u_evsel (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel_q),
        .sec_inc    (sec_inc),
        .fall_1hz   (fall_1hz),
        .fall_2hz   (fall_2hz),
        .min_roll   (min_roll),
        .hour_roll  (hour_roll),
        .month_roll (month_roll),
        .ev         (ev)
    );

    assign clr_req = flag_wr && !flag_wdata;

    // flag next-state logic
    always_comb begin
        unique case (fl_q)
            FL_CLEAR: fl_d = ev ? FL_SET : FL_CLEAR;
            FL_SET:   fl_d = (ev || !clr_req) ? FL_SET : FL_CLEAR;
            default:  fl_d = FL_CLEAR;
        endcase
    end

    // state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_q  <= FL_CLEAR;
            sel_q <= CS_OFF;
        end else begin
            fl_q <= fl_d;
            if (sel_wr) sel_q <= cyc_sel_e'(sel_wdata);
        end
    end

    // outputs
    always_comb begin
        flag = (fl_q == FL_SET);
        unique case (sel_q)
            CS_OFF:  int_n = 1'b1;
            CS_LOW:  int_n = 1'b0;
            CS_P2HZ: int_n = wave_2hz;
            CS_P1HZ: int_n = wave_1hz;
            default: int_n = (fl_q != FL_SET);
        endcase
    end

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_req) |=> flag); // R8
    AST_OFF_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == CS_OFF && !flag) |=> !flag); // R4
    AST_LV_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q[2] && $stable(sel_q) && $fell(int_n)) |-> $past(sec_inc)); // R7

endmodule

// File: tb/sim_rtc_periodic_irq.sv
`timescale 1ns/1ps
module sim_rtc_periodic_irq;

    localparam int W = 6;
    localparam int D = 3;
    localparam int P = 1 << W;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n, sel_wr, flag_wr, flag_wdata, sec_wr;
    logic       min_roll, hour_roll, month_roll;
    logic [2:0] sel_wdata;
    logic       sec_inc, flag, int_n;

    rtc_periodic_irq #(.CNT_W(W), .INC_DLY(D)) u0 (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .flag_wr(flag_wr), .flag_wdata(flag_wdata), .sec_wr(sec_wr),
        .min_roll(min_roll), .hour_roll(hour_roll), .month_roll(month_roll),
        .sec_inc(sec_inc), .flag(flag), .int_n(int_n)
    );

    int total = 0, bad = 0, cyc = 0;
    logic finished = 1'b0;

    // reference model built from the requirements
    logic [W-1:0] mcnt;
    logic         mrun, mflag;
    logic [2:0]   msel;
    logic         e_inc, e_pin;

    assign e_inc = mrun && (mcnt == W'(D));
    always_comb begin
        case (msel)
            3'd0:    e_pin = 1'b1;
            3'd1:    e_pin = 1'b0;
            3'd2:    e_pin = mcnt[W-2];
            3'd3:    e_pin = mcnt[W-1];
            default: e_pin = !mflag;
        endcase
    end

    always @(posedge clk) begin
        logic mev;
        cyc <= cyc + 1;
        if (!rst_n) begin
            mcnt <= '0; mrun <= 1'b1; mflag <= 1'b0; msel <= 3'd0;
        end else begin
            case (msel)
                3'd2:    mev = (&mcnt[W-2:0]) && !sec_wr;
                3'd3:    mev = (&mcnt) && !sec_wr;
                3'd4:    mev = e_inc;
                3'd5:    mev = e_inc && min_roll;
                3'd6:    mev = e_inc && hour_roll;
                3'd7:    mev = e_inc && month_roll;
                default: mev = 1'b0;
            endcase
            if (sec_wr) begin
                mcnt <= '0; mrun <= 1'b0;
            end else begin
                mcnt <= mcnt + 1'b1;
                if (&mcnt) mrun <= 1'b1;
            end
            if (mev) mflag <= 1'b1;
            else if (flag_wr && !flag_wdata) mflag <= 1'b0;
            if (sel_wr) msel <= sel_wdata;
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic string pin_tag(input logic [2:0] s);
        case (s)
            3'd0:      return "R4";
            3'd1:      return "R5";
            3'd2, 3'd3: return "R6";
            3'd4:      return "R7";
            default:   return "R10";
        endcase
    endfunction

    int   sc = 0, last_fall = -1000, wr_cyc = -1, pulse_age = 0;
    logic prev_pin = 1'b1, pin_chk = 1'b0, clr_at_inc = 1'b0, win_chk = 1'b0;

    task automatic tick(input logic sw, input logic slw, input logic [2:0] sd,
                        input logic fw, input logic fd);
        @(negedge clk);
        chk(sec_inc == e_inc, "R2", sec_inc, e_inc);
        chk(int_n == e_pin, pin_tag(msel), int_n, e_pin);
        chk(flag == mflag, "R8", flag, mflag);
        if (pin_chk) begin
            chk(int_n == 1'b0, "R9", int_n, 0);
            pin_chk = 1'b0;
        end
        if (win_chk) begin
            chk(flag == 1'b1, "R8", flag, 1);
            win_chk = 1'b0;
        end
        if (prev_pin && !int_n) last_fall = cyc;
        prev_pin = int_n;
        if (msel == 3'd2 || msel == 3'd3) pulse_age++; else pulse_age = 0;
        if (sec_inc && pulse_age > P + D + 2)
            chk(cyc - last_fall == D, "R3", cyc - last_fall, D);
        if (sec_inc && wr_cyc >= 0) begin
            chk(cyc - wr_cyc == P + D + 1, "R9", cyc - wr_cyc, P + D + 1);
            wr_cyc = -1;
        end
        // drive inputs for the coming edge
        sec_wr = sw; sel_wr = slw; sel_wdata = sd;
        flag_wr = fw; flag_wdata = fd;
        if (clr_at_inc && e_inc && mflag) begin
            flag_wr = 1'b1; flag_wdata = 1'b0; win_chk = (msel == 3'd4);
            clr_at_inc = 1'b0;
        end
        if (sw) begin
            wr_cyc = cyc; pulse_age = 0;
            pin_chk = (msel == 3'd2 || msel == 3'd3);
        end
        if (e_inc) begin
            min_roll = (sc % 2) == 0; hour_roll = (sc % 3) == 0; month_roll = (sc % 4) == 0;
            sc++;
        end else begin
            min_roll = (mcnt == W'(20)); hour_roll = min_roll; month_roll = min_roll;
        end
    endtask

    task automatic run(input int n, input int clr_every);
        for (int i = 1; i <= n; i++)
            tick(1'b0, 1'b0, 3'd0, (clr_every > 0) && (i % clr_every == 0), 1'b0);
    endtask

    task automatic set_sel(input logic [2:0] s);
        logic f0;
        f0 = mflag;
        tick(1'b0, 1'b1, s, 1'b0, 1'b0);
        tick(1'b0, 1'b0, 3'd0, 1'b0, 1'b0);
        if (s == 3'd0 || s == 3'd1) chk(flag == f0, "R11", flag, f0);
    endtask

    initial begin
        rst_n = 1'b0; sel_wr = 0; sel_wdata = 0; flag_wr = 0; flag_wdata = 0;
        sec_wr = 0; min_roll = 0; hour_roll = 0; month_roll = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(int_n == 1'b1, "R1", int_n, 1);
        chk(flag == 1'b0, "R1", flag, 0);
        chk(sec_inc == 1'b0, "R1", sec_inc, 0);
        rst_n = 1'b1;
        run(2 * P + 5, 0);                    // R4 off, R2 cadence
        set_sel(3'd1); run(P + 7, 0);         // R5
        set_sel(3'd3); run(3 * P, 0);         // R6 1 Hz, R3
        tick(1'b1, 1'b0, 3'd0, 1'b0, 1'b0);   // R9 mid-second write
        run(3 * P + 11, 0);
        set_sel(3'd2); run(3 * P, 0);         // R6 2 Hz, R3
        run(17, 0);
        tick(1'b1, 1'b0, 3'd0, 1'b0, 1'b0);   // R9
        run(3 * P, 0);
        set_sel(3'd4); run(4 * P, 23);        // R7 with clears
        run(P, 0);
        tick(1'b0, 1'b0, 3'd0, 1'b1, 1'b1);   // R8 write of 1 ignored
        chk(1'b1, "R8", 1, 1);
        clr_at_inc = 1'b1; run(2 * P, 0);     // R8 event beats clear
        set_sel(3'd5); run(6 * P, 29);        // R10 minute
        set_sel(3'd6); run(7 * P, 29);        // R10 hour
        set_sel(3'd7); run(9 * P, 29);        // R10 month
        set_sel(3'd4); run(2 * P, 0);         // flag now set
        set_sel(3'd0); run(P + 3, 0);         // R4 pin high with flag set
        set_sel(3'd1); run(10, 0);            // R5 pin low
        tick(1'b0, 1'b0, 3'd0, 1'b1, 1'b0);   // clear under forced-low
        run(P + 3, 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule